// File: doc/BRIEF.md
# Extended Eleven-Bit Stack Pointer

This block keeps the stack pointer for a small 8-bit microcontroller core whose stack may grow past the 256 bytes of internal RAM and into on-chip extended RAM. The pointer is 11 bits wide. It is stored as an 8-bit low byte and a 3-bit high extension, and software can read and write both as special function registers. A push (or call) strobe moves the pointer up before the write. A pop (or return) strobe reads at the pointer and then moves it down.

A configuration input chooses the mode. In classic mode the pointer moves only within its low byte, so the stack stays in internal RAM at 000h to 0FFh. In extended mode the full 11-bit value moves, and an increment from 0FFh carries into 100h. The block drives a stack address that already accounts for a push in progress. It also drives a select line that steers the access to extended RAM whenever the address lies at 100h or above. The lowest 256 bytes of extended RAM therefore never hold stack data.

The core connects its push and pop strobes, and its register bus, to this unit. It then uses the address and select outputs to reach the RAM arrays, which lie outside this block.

Top module: `ext_stack_ptr`

## Requirements
- R1: After reset the pointer is 007h. The low register reads 07h and the high register reads 00h.
- R2: Register address 81h reads and writes the low byte. A write to address B7h stores wdata[2:0] as pointer bits 10:8, and a read of B7h returns {5'b00000, bits 10:8}. Any other address reads 00h, holds sfr_hit_o low, and leaves the pointer unchanged when written.
- R3: During a push cycle, stack_addr_o shows the pointer plus one. After the clock edge the pointer holds that value. In extended mode (ext_en=1) the full 11 bits are incremented, and 7FFh wraps to 000h.
- R4: In classic mode (ext_en=0) a push increments only the low byte, and 0FFh wraps to x00h. Pointer bits 10:8 are left unchanged.
- R5: During a pop cycle, stack_addr_o shows the current pointer, and after the edge the pointer is one less. In extended mode this is an 11-bit decrement where 000h wraps to 7FFh. In classic mode only the low byte is decremented, with wrap, and bits 10:8 are unchanged.
- R6: xram_sel_o is 1 exactly when ext_en=1 and stack_addr_o[10:8] is non-zero.
- R7: When push_i and pop_i are asserted together, the pointer does not change and stack_addr_o shows the current pointer.
- R8: A register write to 81h or B7h that coincides with a push or pop takes effect, and the stack operation is discarded. stack_addr_o then shows the current pointer.
- R9: In classic mode stack_addr_o[10:8] is 0 whatever the high register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_en | input | 1 | 1 selects the extended 11-bit stack, 0 selects the classic 8-bit stack |
| push_i | input | 1 | Push or call strobe (pre-increment) |
| pop_i | input | 1 | Pop or return strobe (post-decrement) |
| sfr_wr_i | input | 1 | Register write strobe |
| sfr_addr_i | input | 8 | Register address |
| sfr_wdata_i | input | 8 | Register write data |
| sfr_rdata_o | output | 8 | Register read data for sfr_addr_i (combinational) |
| sfr_hit_o | output | 1 | sfr_addr_i selects one of this block's registers |
| stack_addr_o | output | 11 | Stack RAM address for the current cycle |
| xram_sel_o | output | 1 | 1 steers stack_addr_o to extended RAM, 0 to internal RAM |

## Verification
On every cycle the assertions check several relations. The pointer moves by exactly one in the direction of an accepted push or pop, in the width the mode gives, and it holds still when both strobes collide. A low-byte write lands even when it coincides with a stack operation. The select line never rises in classic mode, and the upper bits of the high register never read back as non-zero. Other behaviour shows only in the bench's sweep, which visits every one of the 2048 pointer values in both modes and computes the expected results arithmetically: the wrap points at 0FFh, 7FFh and 000h, the exact value of the combinational push address, the reset value, and the ignored writes to other addresses.

// File: rtl/xsp_pkg.sv
package xsp_pkg;
  localparam int LO_W  = 8;
  localparam int HI_W  = 3;
  localparam int PTR_W = LO_W + HI_W;

  localparam logic [7:0] DEF_LO_ADDR = 8'h81;
  localparam logic [7:0] DEF_HI_ADDR = 8'hB7;
  localparam logic [PTR_W-1:0] DEF_RESET = 11'h007;

  typedef logic [PTR_W-1:0] ptr_t;

  // Move the pointer one step. Extended mode: full width. Classic: low byte only.
  function automatic ptr_t ptr_step(input ptr_t p, input logic ext, input logic up);
    ptr_t r;
    logic [LO_W-1:0] lo;
    if (ext) begin
      r = up ? p + ptr_t'(1) : p - ptr_t'(1);
    end else begin
      lo = p[LO_W-1:0];
      lo = up ? lo + LO_W'(1) : lo - LO_W'(1);
      r  = {p[PTR_W-1:LO_W], lo};
    end
    return r;
  endfunction

  // Address seen by the RAM: in classic mode the extension bits are masked.
  function automatic ptr_t eff_addr(input ptr_t p, input logic ext);
    return ext ? p : {{HI_W{1'b0}}, p[LO_W-1:0]};
  endfunction

  // Extended RAM is selected above the internal 256-byte window.
  function automatic logic in_xram(input ptr_t a, input logic ext);
    return ext && (a[PTR_W-1:LO_W] != '0);
  endfunction
endpackage

// File: rtl/xsp_sfr_decode.sv
module xsp_sfr_decode
  import xsp_pkg::*;
#(
  parameter logic [7:0] LO_ADDR = DEF_LO_ADDR,
  parameter logic [7:0] HI_ADDR = DEF_HI_ADDR
) (
  input  logic             sfr_wr_i,
  input  logic [7:0]       sfr_addr_i,
  input  logic [PTR_W-1:0] ptr_q,
  output logic             wr_lo,
  output logic             wr_hi,
  output logic             hit,
  output logic [7:0]       rdata
);
  logic sel_lo, sel_hi;

  always_comb begin
    sel_lo = (sfr_addr_i == LO_ADDR);
    sel_hi = (sfr_addr_i == HI_ADDR);
    wr_lo  = sfr_wr_i && sel_lo;
    wr_hi  = sfr_wr_i && sel_hi;
    hit    = sel_lo || sel_hi;
    if (sel_lo)      rdata = ptr_q[LO_W-1:0];
    else if (sel_hi) rdata = {{(8-HI_W){1'b0}}, ptr_q[PTR_W-1:LO_W]};
    else             rdata = 8'h00;
  end
endmodule

// File: rtl/xsp_step.sv
module xsp_step
  import xsp_pkg::*;
(
  input  logic             ext_en,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             wr_any,
  input  logic [PTR_W-1:0] ptr_q,
  output logic             push_evt,
  output logic             pop_evt,
  output logic [PTR_W-1:0] ptr_moved,
  output logic [PTR_W-1:0] stack_addr,
  output logic             xram_sel
);
  logic [PTR_W-1:0] ptr_up, ptr_dn;

  always_comb begin
    push_evt  = push_i && !pop_i && !wr_any;
    pop_evt   = pop_i && !push_i && !wr_any;
    ptr_up    = ptr_step(ptr_q, ext_en, 1'b1);
    ptr_dn    = ptr_step(ptr_q, ext_en, 1'b0);
    ptr_moved = push_evt ? ptr_up : (pop_evt ? ptr_dn : ptr_q);
    // pre-increment: a push addresses the new top; a pop reads the old top
    stack_addr = eff_addr(push_evt ? ptr_up : ptr_q, ext_en);
    xram_sel   = in_xram(stack_addr, ext_en);
  end
endmodule

// File: rtl/xsp_reg.sv
module xsp_reg
  import xsp_pkg::*;
#(
  parameter logic [PTR_W-1:0] RESET_VAL = DEF_RESET
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       wdata,
  input  logic [PTR_W-1:0] ptr_moved,
  output logic [PTR_W-1:0] ptr_q
);
  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_moved;
    if (wr_lo) ptr_d[LO_W-1:0]     = wdata[LO_W-1:0];
    if (wr_hi) ptr_d[PTR_W-1:LO_W] = wdata[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= RESET_VAL;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/ext_stack_ptr.sv
module ext_stack_ptr
  import xsp_pkg::*;
#(
  parameter logic [7:0]       LO_ADDR   = DEF_LO_ADDR,
  parameter logic [7:0]       HI_ADDR   = DEF_HI_ADDR,
  parameter logic [PTR_W-1:0] RESET_VAL = DEF_RESET
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_en,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             sfr_wr_i,
  input  logic [7:0]       sfr_addr_i,
  input  logic [7:0]       sfr_wdata_i,
  output logic [7:0]       sfr_rdata_o,
  output logic             sfr_hit_o,
  output logic [PTR_W-1:0] stack_addr_o,
  output logic             xram_sel_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_moved;
  logic             wr_lo, wr_hi;
  logic             push_evt, pop_evt;

  xsp_sfr_decode #(.LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)) u_dec (
    .sfr_wr_i  (sfr_wr_i),
    .sfr_addr_i(sfr_addr_i),
    .ptr_q     (ptr_q),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .hit       (sfr_hit_o),
    .rdata     (sfr_rdata_o)
  );

  xsp_step u_step (
    .ext_en    (ext_en),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .wr_any    (wr_lo || wr_hi),
    .ptr_q     (ptr_q),
    .push_evt  (push_evt),
    .pop_evt   (pop_evt),
    .ptr_moved (ptr_moved),
    .stack_addr(stack_addr_o),
    .xram_sel  (xram_sel_o)
  );

  xsp_reg #(.RESET_VAL(RESET_VAL)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .wdata    (sfr_wdata_i),
    .ptr_moved(ptr_moved),
    .ptr_q    (ptr_q)
  );
endmodule

// File: rtl/xsp_chk.sv
module xsp_chk
  import xsp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ext_en,
  input logic             push_i,
  input logic             pop_i,
  input logic             sfr_wr_i,
  input logic [7:0]       sfr_addr_i,
  input logic [7:0]       sfr_wdata_i,
  input logic [7:0]       sfr_rdata_o,
  input logic [PTR_W-1:0] stack_addr_o,
  input logic             xram_sel_o,
  input logic [PTR_W-1:0] ptr_q,
  input logic             push_evt,
  input logic             pop_evt
);
  // R3
  ext_push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt && ext_en |=> ptr_q == $past(ptr_q) + 11'd1);
  // R4
  classic_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt && !ext_en |=> (ptr_q[7:0] == $past(ptr_q[7:0]) + 8'd1)
                            && (ptr_q[10:8] == $past(ptr_q[10:8])));
  // R5
  ext_pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt && ext_en |=> ptr_q == $past(ptr_q) - 11'd1);
  // R6
  xsel_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xram_sel_o |-> ext_en && (stack_addr_o[10:8] != 3'd0));
  // R9
  classic_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en |-> stack_addr_o[10:8] == 3'd0);
  // R7
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && pop_i && !sfr_wr_i |=> $stable(ptr_q));
  // R2
  hi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_addr_i == DEF_HI_ADDR |-> sfr_rdata_o[7:3] == 5'd0);
  // R8
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_wr_i && sfr_addr_i == DEF_LO_ADDR |=> ptr_q[7:0] == $past(sfr_wdata_i));
endmodule

bind ext_stack_ptr xsp_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ext_en      (ext_en),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .sfr_wr_i    (sfr_wr_i),
  .sfr_addr_i  (sfr_addr_i),
  .sfr_wdata_i (sfr_wdata_i),
  .sfr_rdata_o (sfr_rdata_o),
  .stack_addr_o(stack_addr_o),
  .xram_sel_o  (xram_sel_o),
  .ptr_q       (ptr_q),
  .push_evt    (push_evt),
  .pop_evt     (pop_evt)
);

// File: tb/tb_ext_stack_ptr.sv
`timescale 1ns/1ps
module tb_ext_stack_ptr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_en = 1'b0;
  logic        push_i = 1'b0, pop_i = 1'b0, sfr_wr_i = 1'b0;
  logic [7:0]  sfr_addr_i = 8'h00, sfr_wdata_i = 8'h00;
  logic [7:0]  sfr_rdata_o;
  logic        sfr_hit_o;
  logic [10:0] stack_addr_o;
  logic        xram_sel_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ext_stack_ptr dut (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .push_i(push_i), .pop_i(pop_i),
    .sfr_wr_i(sfr_wr_i), .sfr_addr_i(sfr_addr_i), .sfr_wdata_i(sfr_wdata_i),
    .sfr_rdata_o(sfr_rdata_o), .sfr_hit_o(sfr_hit_o),
    .stack_addr_o(stack_addr_o), .xram_sel_o(xram_sel_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference arithmetic, stated from the requirements.
  function automatic int ref_step(input int p, input int ext, input int up);
    int d = up ? 1 : -1;
    if (ext != 0) return (p + d + 2048) % 2048;
    return (p / 256) * 256 + ((p % 256) + d + 256) % 256;
  endfunction
  function automatic int ref_addr(input int p, input int ext);
    return ext != 0 ? p : p % 256;
  endfunction

  task automatic idle();
    push_i = 0; pop_i = 0; sfr_wr_i = 0;
  endtask

  task automatic set_ptr(input int p);
    @(negedge clk);
    sfr_wr_i = 1; sfr_addr_i = 8'h81; sfr_wdata_i = 8'(p % 256);
    @(negedge clk);
    sfr_addr_i = 8'hB7; sfr_wdata_i = {5'b10110, 3'(p / 256)};
    @(negedge clk);
    idle();
  endtask

  task automatic read_ptr(input string req, output int v);
    int lo, hi;
    sfr_addr_i = 8'h81; #0.5;
    lo = sfr_rdata_o;
    sfr_addr_i = 8'hB7; #0.5;
    hi = sfr_rdata_o;
    check("R2 hi upper bits", hi / 8, 0);
    v = (hi % 8) * 256 + lo;
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    // R1: reset value
    read_ptr("R1", v);
    check("R1 reset pointer", v, 'h007);
    rst_n = 1;
    @(negedge clk);
    read_ptr("R1", v);
    check("R1 pointer after release", v, 'h007);
    sfr_addr_i = 8'h81; #0.5; check("R1 low read", sfr_rdata_o, 'h07);
    check("R2 hit low", sfr_hit_o, 1);
    sfr_addr_i = 8'h80; #0.5;
    check("R2 other addr read", sfr_rdata_o, 0);
    check("R2 other addr hit", sfr_hit_o, 0);
    // R2: write to other addresses is ignored
    for (int a = 0; a < 256; a += 17) begin
      if (a == 'h81 || a == 'hB7) continue;
      @(negedge clk);
      sfr_wr_i = 1; sfr_addr_i = 8'(a); sfr_wdata_i = 8'hFF;
      @(negedge clk);
      idle();
      read_ptr("R2", v);
      check("R2 foreign write ignored", v, 'h007);
    end

    // Full sweep of all pointer values in both modes
    for (int ext = 0; ext < 2; ext++) begin
      ext_en = ext[0];
      for (int p = 0; p < 2048; p++) begin
        set_ptr(p);
        read_ptr("R2", v);
        check("R2 write/readback", v, p);
        // push (R3 ext, R4 classic)
        push_i = 1; #0.5;
        check(ext ? "R3 push addr" : "R4 push addr", stack_addr_o,
              ref_addr(ref_step(p, ext, 1), ext));
        check("R6 push xsel", xram_sel_o, (ext != 0 && ref_step(p, ext, 1) >= 256) ? 1 : 0);
        @(negedge clk); idle();
        read_ptr("R3", v);
        check(ext ? "R3 push ptr" : "R4 push ptr", v, ref_step(p, ext, 1));
        // pop (R5) from the new value
        pop_i = 1; #0.5;
        check("R5 pop addr", stack_addr_o, ref_addr(ref_step(p, ext, 1), ext));
        check(ext ? "R6 pop xsel" : "R9 pop xsel", xram_sel_o,
              (ext != 0 && ref_step(p, ext, 1) >= 256) ? 1 : 0);
        @(negedge clk); pop_i = 1; #0.5;
        check("R5 second pop addr", stack_addr_o, ref_addr(p, ext));
        @(negedge clk); idle();
        read_ptr("R5", v);
        check("R5 pop ptr", v, ref_step(p, ext, 0));
      end
    end

    // R7: push and pop together
    ext_en = 1;
    set_ptr('h2FF);
    push_i = 1; pop_i = 1; #0.5;
    check("R7 collide addr", stack_addr_o, 'h2FF);
    @(negedge clk); idle();
    read_ptr("R7", v);
    check("R7 collide hold", v, 'h2FF);

    // R8: register write beats push
    push_i = 1; sfr_wr_i = 1; sfr_addr_i = 8'h81; sfr_wdata_i = 8'h40; #0.5;
    check("R8 addr during write", stack_addr_o, 'h2FF);
    @(negedge clk); idle();
    read_ptr("R8", v);
    check("R8 write wins push", v, 'h240);
    pop_i = 1; sfr_wr_i = 1; sfr_addr_i = 8'hB7; sfr_wdata_i = 8'h05;
    @(negedge clk); idle();
    read_ptr("R8", v);
    check("R8 write wins pop", v, 'h540);

    // R9: classic mode masks high bits
    ext_en = 0; #0.5;
    check("R9 classic addr", stack_addr_o, 'h040);
    check("R9 classic xsel", xram_sel_o, 0);
    ext_en = 1; #0.5;
    check("R6 ext xsel", xram_sel_o, 1);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule